// File: doc/BRIEF.md
# Update-Broadcast Snoop Coherence Controller

This block is the coherence controller of one private cache on a shared bus. Other copies stay current because a write to a shared line is sent on the bus as a word update and is not turned into an invalidation. Each resident line is in one of four valid states, and an empty slot is marked as such. The states are exclusive-clean, shared-clean, exclusive-owned and shared-owned. The cache that owns a line is the one that must write it back to memory. Each line holds a single data word, and the lines are mapped directly by the low address bits.

The CPU port takes one request per cycle. Any bus read or word-update that the request needs is placed on the bus port in the same cycle. That cycle's shared-line response and fill data decide the new state. Read data and a done flag appear one cycle after the request. A separate write-back port carries the old word when an owned line is evicted. The snoop port sees reads and updates issued by other caches. It answers with a shared flag, and with the data when this cache owns the line. It also applies update data to a matching line. A competitive mode, set by a parameter, drops a copy that keeps receiving updates without local use.

Top module: `dragon_snoop_ctrl`

## Requirements
- R1: After reset every slot is empty. A snoop to any address leaves snpShared and snpSupply low, and any CPU read misses and issues a bus read.
- R2: A CPU read miss issues busValid with busKind=0 (read) and busAddr=cpuAddr. The line fills as shared-clean if busShared is high and as exclusive-clean otherwise, and busFillData is stored. One cycle after any cpuReq, cpuDone is high. For a read, cpuRdata is the line's word.
- R3: A snoop read (snpKind=0) that hits an exclusive-clean line asserts snpShared, leaves snpSupply low and moves the line to shared-clean.
- R4: A CPU write that hits an exclusive-clean or exclusive-owned line makes no bus transaction (busValid low). The line becomes exclusive-owned with the new word.
- R5: A CPU write that hits a shared line, or that misses, issues busValid with busKind=1 (update), busAddr=cpuAddr and busData=cpuWdata. The line becomes shared-owned if busShared is high and exclusive-owned otherwise. In the exclusive-owned case later writes stay local.
- R6: A snoop update (snpKind=1) that hits a held line replaces its word with snpData, asserts snpShared and leaves the line shared-clean. An owner loses ownership this way.
- R7: A snoop read that hits an owned line asserts snpShared and snpSupply, with snpSupplyData equal to the line's word. An exclusive-owned line becomes shared-owned.
- R8: A CPU miss that evicts an owned line asserts wbValid in the same cycle, with wbAddr equal to the old address and wbData equal to the old word. Evicting a clean line asserts nothing.
- R9: In competitive mode a line accepts UPDATE_LIMIT consecutive snoop updates. The next update empties it: snpShared stays low, the word is not taken and a later CPU read misses. Any CPU access to the line restarts the count.
- R10: When a snoop and a CPU request hit the same slot in one cycle, the snoop is applied first and the CPU request acts on the result.
- R11: A CPU read hit makes no bus transaction and returns the stored word.
- R12: The address index is cpuAddr[IDX_W-1:0] and the tag is the remaining upper bits. A snoop with a different tag in the same slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU request this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | CPU word address |
| cpuWdata | input | DATA_W | CPU write word |
| cpuDone | output | 1 | Request of the previous cycle completed |
| cpuRdata | output | DATA_W | Read word, valid with cpuDone |
| busValid | output | 1 | Bus transaction issued this cycle |
| busKind | output | 1 | 0 = read, 1 = word update |
| busAddr | output | ADDR_W | Bus transaction address |
| busData | output | DATA_W | Update word |
| busShared | input | 1 | Shared-line response for this cycle's transaction |
| busFillData | input | DATA_W | Fill word for a bus read |
| wbValid | output | 1 | Owned line evicted this cycle |
| wbAddr | output | ADDR_W | Address of the evicted word |
| wbData | output | DATA_W | Evicted word |
| snpValid | input | 1 | Foreign bus transaction to snoop |
| snpKind | input | 1 | 0 = read, 1 = word update |
| snpAddr | input | ADDR_W | Snooped address |
| snpData | input | DATA_W | Snooped update word |
| snpShared | output | 1 | This cache keeps a copy |
| snpSupply | output | 1 | This cache owns and supplies the word |
| snpSupplyData | output | DATA_W | Supplied word |

## Verification
A foreign snoop and a local CPU request can reach the same slot in the same cycle. In that case the CPU's hit decision, its bus transaction and its returned word all depend on the state the snoop has just produced. The bench provokes this both in directed cases and in random traffic, where roughly one cycle in three aims the snoop at the CPU's own address. Examples are an update arriving beside a read and a foreign read arriving beside a write to an exclusive-owned line. Every combinational output and the delayed read word are judged against a bench model that applies the snoop before the CPU request.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_UE    = 3'd1,
    ST_US    = 3'd2,
    ST_OE    = 3'd3,
    ST_OS    = 3'd4
  } line_state_e;

  localparam logic KIND_READ   = 1'b0;
  localparam logic KIND_UPDATE = 1'b1;

  typedef struct packed {
    logic snpWe;
    logic cpuWe;
    logic rspLoad;
  } strobe_t;

endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
  import dragon_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  line_state_e       snpStateW,
  input  logic [DATA_W-1:0] snpDataW,
  input  logic [CNT_W-1:0]  snpCntW,
  input  line_state_e       cpuStateW,
  input  logic [TAG_W-1:0]  cpuTagW,
  input  logic [DATA_W-1:0] cpuDataW,
  input  logic [CNT_W-1:0]  cpuCntW,
  input  logic [DATA_W-1:0] rspDataW,
  output line_state_e       snpStateR,
  output logic [TAG_W-1:0]  snpTagR,
  output logic [DATA_W-1:0] snpDataR,
  output logic [CNT_W-1:0]  snpCntR,
  output line_state_e       cpuStateR,
  output logic [TAG_W-1:0]  cpuTagR,
  output logic [DATA_W-1:0] cpuDataR,
  output logic [CNT_W-1:0]  cpuCntR,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData
);

  line_state_e       stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];
  logic [CNT_W-1:0]  cntQ   [LINES];

  assign snpStateR = stateQ[snpIdx];
  assign snpTagR   = tagQ[snpIdx];
  assign snpDataR  = dataQ[snpIdx];
  assign snpCntR   = cntQ[snpIdx];
  assign cpuStateR = stateQ[cpuIdx];
  assign cpuTagR   = tagQ[cpuIdx];
  assign cpuDataR  = dataQ[cpuIdx];
  assign cpuCntR   = cntQ[cpuIdx];

  // CPU port carries the full post-snoop entry, so it wins on a shared slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= ST_EMPTY;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
        cntQ[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strobes.cpuWe && cpuIdx == IDX_W'(i)) begin
          stateQ[i] <= cpuStateW;
          tagQ[i]   <= cpuTagW;
          dataQ[i]  <= cpuDataW;
          cntQ[i]   <= cpuCntW;
        end else if (strobes.snpWe && snpIdx == IDX_W'(i)) begin
          stateQ[i] <= snpStateW;
          dataQ[i]  <= snpDataW;
          cntQ[i]   <= snpCntW;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone <= 1'b0;
      rspData <= '0;
    end else begin
      rspDone <= strobes.rspLoad;
      if (strobes.rspLoad) rspData <= rspDataW;
    end
  end

endmodule

// File: rtl/dragon_coherence_ctrl.sv
module dragon_coherence_ctrl
  import dragon_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int IDX_W        = 2,
  parameter int TAG_W        = 6,
  parameter int CNT_W        = 2,
  parameter bit COMPETITIVE  = 1'b1,
  parameter int UPDATE_LIMIT = 3
) (
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              busShared,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic              snpKind,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  input  line_state_e       snpStateR,
  input  logic [TAG_W-1:0]  snpTagR,
  input  logic [DATA_W-1:0] snpDataR,
  input  logic [CNT_W-1:0]  snpCntR,
  input  line_state_e       cpuStateR,
  input  logic [TAG_W-1:0]  cpuTagR,
  input  logic [DATA_W-1:0] cpuDataR,
  input  logic [CNT_W-1:0]  cpuCntR,
  output strobe_t           strobes,
  output logic [IDX_W-1:0]  snpIdx,
  output logic [IDX_W-1:0]  cpuIdx,
  output line_state_e       snpStateW,
  output logic [DATA_W-1:0] snpDataW,
  output logic [CNT_W-1:0]  snpCntW,
  output line_state_e       cpuStateW,
  output logic [TAG_W-1:0]  cpuTagW,
  output logic [DATA_W-1:0] cpuDataW,
  output logic [CNT_W-1:0]  cpuCntW,
  output logic [DATA_W-1:0] rspDataW,
  output logic              busValid,
  output logic              busKind,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              snpShared,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpSupplyData
);

  logic [TAG_W-1:0] snpTag, cpuTag;
  logic             snpHit, limitHit, sameLine, cpuHit, ownedVictim;
  logic [CNT_W-1:0] cntBump;
  line_state_e      baseState;
  logic [DATA_W-1:0] baseData;
  logic [CNT_W-1:0] baseCnt;

  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];
  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];

  assign snpHit = snpValid && (snpStateR != ST_EMPTY) && (snpTagR == snpTag);

  generate
    if (COMPETITIVE) begin : gCompete
      assign limitHit = (snpCntR == CNT_W'(UPDATE_LIMIT));
      assign cntBump  = snpCntR + 1'b1;
    end else begin : gPlain
      assign limitHit = 1'b0;
      assign cntBump  = '0;
    end
  endgenerate

  // Snoop side
  always_comb begin
    snpStateW     = snpStateR;
    snpDataW      = snpDataR;
    snpCntW       = snpCntR;
    snpShared     = 1'b0;
    snpSupply     = 1'b0;
    snpSupplyData = '0;
    if (snpHit) begin
      if (snpKind == KIND_READ) begin
        snpShared = 1'b1;
        if (snpStateR == ST_OE || snpStateR == ST_OS) begin
          snpSupply     = 1'b1;
          snpSupplyData = snpDataR;
        end
        if (snpStateR == ST_UE) snpStateW = ST_US;
        if (snpStateR == ST_OE) snpStateW = ST_OS;
      end else if (limitHit) begin
        snpStateW = ST_EMPTY;
      end else begin
        snpShared = 1'b1;
        snpStateW = ST_US;
        snpDataW  = snpData;
        snpCntW   = cntBump;
      end
    end
  end

  // CPU side works on the post-snoop view of its slot
  assign sameLine    = snpHit && (snpIdx == cpuIdx);
  assign baseState   = sameLine ? snpStateW : cpuStateR;
  assign baseData    = sameLine ? snpDataW  : cpuDataR;
  assign baseCnt     = sameLine ? snpCntW   : cpuCntR;
  assign cpuHit      = (baseState != ST_EMPTY) && (cpuTagR == cpuTag);
  assign ownedVictim = !cpuHit && (baseState == ST_OE || baseState == ST_OS);

  always_comb begin
    cpuStateW = baseState;
    cpuTagW   = cpuTagR;
    cpuDataW  = baseData;
    cpuCntW   = baseCnt;
    rspDataW  = baseData;
    busValid  = 1'b0;
    busKind   = KIND_READ;
    busAddr   = cpuAddr;
    busData   = cpuWdata;
    wbValid   = 1'b0;
    wbAddr    = {cpuTagR, cpuIdx};
    wbData    = baseData;
    if (cpuReq) begin
      cpuCntW = '0;
      wbValid = ownedVictim;
      if (!cpuWrite) begin
        if (!cpuHit) begin
          busValid  = 1'b1;
          cpuStateW = busShared ? ST_US : ST_UE;
          cpuTagW   = cpuTag;
          cpuDataW  = busFillData;
          rspDataW  = busFillData;
        end
      end else if (cpuHit && (baseState == ST_UE || baseState == ST_OE)) begin
        cpuStateW = ST_OE;
        cpuDataW  = cpuWdata;
      end else begin
        busValid  = 1'b1;
        busKind   = KIND_UPDATE;
        cpuStateW = busShared ? ST_OS : ST_OE;
        cpuTagW   = cpuTag;
        cpuDataW  = cpuWdata;
      end
    end
  end

  assign strobes = '{snpWe: snpHit, cpuWe: cpuReq, rspLoad: cpuReq};

endmodule

// File: rtl/dragon_snoop_ctrl.sv
module dragon_snoop_ctrl
  import dragon_pkg::*;
#(
  parameter int LINES        = 4,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter bit COMPETITIVE  = 1'b1,
  parameter int UPDATE_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busValid,
  output logic              busKind,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  input  logic              busShared,
  input  logic [DATA_W-1:0] busFillData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  input  logic              snpValid,
  input  logic              snpKind,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  output logic              snpShared,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpSupplyData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CNT_W = $clog2(UPDATE_LIMIT + 1);

  strobe_t           strobes;
  logic [IDX_W-1:0]  snpIdx, cpuIdx;
  line_state_e       snpStateW, cpuStateW, snpStateR, cpuStateR;
  logic [DATA_W-1:0] snpDataW, cpuDataW, snpDataR, cpuDataR, rspDataW;
  logic [CNT_W-1:0]  snpCntW, cpuCntW, snpCntR, cpuCntR;
  logic [TAG_W-1:0]  cpuTagW, snpTagR, cpuTagR;

  dragon_coherence_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .CNT_W(CNT_W), .COMPETITIVE(COMPETITIVE), .UPDATE_LIMIT(UPDATE_LIMIT)
  ) uCtrl (
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busShared(busShared), .busFillData(busFillData),
    .snpValid(snpValid), .snpKind(snpKind), .snpAddr(snpAddr), .snpData(snpData),
    .snpStateR(snpStateR), .snpTagR(snpTagR), .snpDataR(snpDataR), .snpCntR(snpCntR),
    .cpuStateR(cpuStateR), .cpuTagR(cpuTagR), .cpuDataR(cpuDataR), .cpuCntR(cpuCntR),
    .strobes(strobes), .snpIdx(snpIdx), .cpuIdx(cpuIdx),
    .snpStateW(snpStateW), .snpDataW(snpDataW), .snpCntW(snpCntW),
    .cpuStateW(cpuStateW), .cpuTagW(cpuTagW), .cpuDataW(cpuDataW), .cpuCntW(cpuCntW),
    .rspDataW(rspDataW),
    .busValid(busValid), .busKind(busKind), .busAddr(busAddr), .busData(busData),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .snpShared(snpShared), .snpSupply(snpSupply), .snpSupplyData(snpSupplyData)
  );

  dragon_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) uStore (
    .clk(clk), .rstN(rstN), .strobes(strobes), .snpIdx(snpIdx), .cpuIdx(cpuIdx),
    .snpStateW(snpStateW), .snpDataW(snpDataW), .snpCntW(snpCntW),
    .cpuStateW(cpuStateW), .cpuTagW(cpuTagW), .cpuDataW(cpuDataW), .cpuCntW(cpuCntW),
    .rspDataW(rspDataW),
    .snpStateR(snpStateR), .snpTagR(snpTagR), .snpDataR(snpDataR), .snpCntR(snpCntR),
    .cpuStateR(cpuStateR), .cpuTagR(cpuTagR), .cpuDataR(cpuDataR), .cpuCntR(cpuCntR),
    .rspDone(cpuDone), .rspData(cpuRdata)
  );

endmodule

// File: rtl/dragon_snoop_chk.sv
module dragon_snoop_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWrite,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic              cpuDone,
  input logic              busValid,
  input logic              busKind,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              wbValid,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              snpShared,
  input logic              snpSupply
);

  assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |=> cpuDone);

  assert_no_done_without_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |=> !cpuDone);

  assert_bus_from_cpu_R5: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (cpuReq && busAddr == cpuAddr));

  assert_update_carries_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busKind) |-> (cpuWrite && busData == cpuWdata));

  assert_supply_is_shared_R7: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> snpShared);

  assert_wb_on_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (busValid && wbAddr != cpuAddr
                 && wbAddr[IDX_W-1:0] == cpuAddr[IDX_W-1:0]));

endmodule

bind dragon_snoop_ctrl dragon_snoop_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuDone(cpuDone), .busValid(busValid), .busKind(busKind),
  .busAddr(busAddr), .busData(busData), .wbValid(wbValid), .wbAddr(wbAddr),
  .snpShared(snpShared), .snpSupply(snpSupply)
);

// File: tb/dragon_snoop_ctrl_test.sv
module dragon_snoop_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 3;
  localparam int S_E = 0, S_UE = 1, S_US = 2, S_OE = 3, S_OS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuWrite = 0;
  logic [7:0] cpuAddr = 0;
  logic [15:0] cpuWdata = 0;
  logic cpuDone;
  logic [15:0] cpuRdata;
  logic busValid, busKind;
  logic [7:0] busAddr;
  logic [15:0] busData;
  logic busShared = 0;
  logic [15:0] busFillData = 0;
  logic wbValid;
  logic [7:0] wbAddr;
  logic [15:0] wbData;
  logic snpValid = 0, snpKind = 0;
  logic [7:0] snpAddr = 0;
  logic [15:0] snpData = 0;
  logic snpShared, snpSupply;
  logic [15:0] snpSupplyData;

  int checks = 0;
  int errors = 0;
  int mState[4];
  int mTag[4];
  int mData[4];
  int mCnt[4];
  bit expDone = 0;
  bit expIsRead = 0;
  int expRd = 0;
  string prevTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dragon_snoop_ctrl uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busValid(busValid), .busKind(busKind), .busAddr(busAddr), .busData(busData),
    .busShared(busShared), .busFillData(busFillData),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .snpValid(snpValid), .snpKind(snpKind), .snpAddr(snpAddr), .snpData(snpData),
    .snpShared(snpShared), .snpSupply(snpSupply), .snpSupplyData(snpSupplyData)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit owned(input int s);
    return s == S_OE || s == S_OS;
  endfunction

  task automatic cycle(input string tag, input bit req, input bit wr, input logic [7:0] addr,
                       input logic [15:0] wd, input bit sv, input bit sk,
                       input logic [7:0] sa, input logic [15:0] sd,
                       input bit bsh, input logic [15:0] fill);
    int si, st, ci, ct;
    bit eShared, eSupply, eBusV, eBusK, eWb, hit;
    int eSupData, eWbAddr, eWbData, rd;
    @(negedge clk);
    chk(prevTag, "cpuDone", int'(cpuDone), int'(expDone));
    if (expDone && expIsRead) chk(prevTag, "cpuRdata", int'(cpuRdata), expRd);
    cpuReq = req; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    snpValid = sv; snpKind = sk; snpAddr = sa; snpData = sd;
    busShared = bsh; busFillData = fill;
    #1;
    si = int'(sa[1:0]); st = int'(sa[7:2]);
    ci = int'(addr[1:0]); ct = int'(addr[7:2]);
    eShared = 0; eSupply = 0; eSupData = 0; eBusV = 0; eBusK = 0; eWb = 0;
    eWbAddr = 0; eWbData = 0; rd = 0;
    // snoop first
    if (sv && mState[si] != S_E && mTag[si] == st) begin
      if (!sk) begin
        eShared = 1;
        if (owned(mState[si])) begin eSupply = 1; eSupData = mData[si]; end
        if (mState[si] == S_UE) mState[si] = S_US;
        if (mState[si] == S_OE) mState[si] = S_OS;
      end else if (mCnt[si] == LIMIT) begin
        mState[si] = S_E;
      end else begin
        eShared = 1; mState[si] = S_US; mData[si] = int'(sd); mCnt[si]++;
      end
    end
    // then CPU
    if (req) begin
      hit = mState[ci] != S_E && mTag[ci] == ct;
      if (!hit && owned(mState[ci])) begin
        eWb = 1; eWbAddr = mTag[ci] * 4 + ci; eWbData = mData[ci];
      end
      mCnt[ci] = 0;
      if (!wr) begin
        if (hit) rd = mData[ci];
        else begin
          eBusV = 1; mState[ci] = bsh ? S_US : S_UE; mTag[ci] = ct;
          mData[ci] = int'(fill); rd = int'(fill);
        end
      end else if (hit && (mState[ci] == S_UE || mState[ci] == S_OE)) begin
        mState[ci] = S_OE; mData[ci] = int'(wd);
      end else begin
        eBusV = 1; eBusK = 1; mState[ci] = bsh ? S_OS : S_OE; mTag[ci] = ct;
        mData[ci] = int'(wd);
      end
    end
    chk(tag, "busValid", int'(busValid), int'(eBusV));
    if (eBusV) begin
      chk(tag, "busKind", int'(busKind), int'(eBusK));
      chk(tag, "busAddr", int'(busAddr), int'(addr));
      if (eBusK) chk(tag, "busData", int'(busData), int'(wd));
    end
    chk(tag, "wbValid", int'(wbValid), int'(eWb));
    if (eWb) begin
      chk(tag, "wbAddr", int'(wbAddr), eWbAddr);
      chk(tag, "wbData", int'(wbData), eWbData);
    end
    chk(tag, "snpShared", int'(snpShared), int'(eShared));
    chk(tag, "snpSupply", int'(snpSupply), int'(eSupply));
    if (eSupply) chk(tag, "snpSupplyData", int'(snpSupplyData), eSupData);
    expDone = req; expIsRead = req && !wr; expRd = rd; prevTag = tag;
  endtask

  task automatic idle(input string tag);
    cycle(tag, 0, 0, 8'h00, 16'h0, 0, 0, 8'h00, 16'h0, 0, 16'h0);
  endtask

  localparam logic [7:0] A = 8'h04, B = 8'h08, C = 8'h05;

  initial begin
    for (int i = 0; i < 4; i++) begin mState[i] = S_E; mTag[i] = 0; mData[i] = 0; mCnt[i] = 0; end
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    cycle("R1", 0, 0, 0, 0, 1, 0, A, 0, 0, 0);
    cycle("R1", 0, 0, 0, 0, 1, 0, 8'h00, 0, 0, 0);
    // R2: read miss fills exclusive-clean
    cycle("R2", 1, 0, A, 0, 0, 0, 0, 0, 0, 16'h1111);
    idle("R2");
    // R3: foreign read of exclusive-clean
    cycle("R3", 0, 0, 0, 0, 1, 0, A, 0, 0, 0);
    // R11: read hit stays local
    cycle("R11", 1, 0, A, 0, 0, 0, 0, 0, 0, 16'hdead);
    // R5: write to shared broadcasts, shared response -> shared-owned
    cycle("R5", 1, 1, A, 16'h2222, 0, 0, 0, 0, 1, 0);
    cycle("R7", 0, 0, 0, 0, 1, 0, A, 0, 0, 0);
    // R5: no sharer answers -> exclusive-owned, next write local (R4)
    cycle("R5", 1, 1, A, 16'h3333, 0, 0, 0, 0, 0, 0);
    cycle("R4", 1, 1, A, 16'h4444, 0, 0, 0, 0, 1, 0);
    cycle("R7", 0, 0, 0, 0, 1, 0, A, 0, 0, 0);
    // R6: foreign update strips ownership
    cycle("R6", 0, 0, 0, 0, 1, 1, A, 16'h5555, 0, 0);
    // R12: other tag, same slot, ignored
    cycle("R12", 0, 0, 0, 0, 1, 1, B, 16'hbad0, 0, 0);
    cycle("R12", 1, 0, A, 0, 0, 0, 0, 0, 0, 16'h0bad);
    // R8: clean eviction silent, owned eviction writes back
    cycle("R8", 1, 1, B, 16'h6666, 0, 0, 0, 0, 0, 0);
    cycle("R8", 1, 0, A, 0, 0, 0, 0, 0, 1, 16'h7777);
    // R9: competitive drop after LIMIT updates, count restarts on CPU use
    cycle("R9", 0, 0, 0, 0, 1, 1, A, 16'h0001, 0, 0);
    cycle("R9", 0, 0, 0, 0, 1, 1, A, 16'h0002, 0, 0);
    cycle("R9", 1, 0, A, 0, 0, 0, 0, 0, 0, 16'h0);
    for (int k = 0; k < LIMIT; k++) cycle("R9", 0, 0, 0, 0, 1, 1, A, 16'h0010 + 16'(k), 0, 0);
    cycle("R9", 0, 0, 0, 0, 1, 1, A, 16'h0099, 0, 0);
    cycle("R9", 1, 0, A, 0, 0, 0, 0, 0, 1, 16'h8888);
    // R10: same-slot snoop and CPU in one cycle
    cycle("R10", 1, 0, A, 0, 1, 1, A, 16'h9999, 0, 16'h0);
    cycle("R10", 1, 1, C, 16'haaaa, 0, 0, 0, 0, 0, 0);
    cycle("R10", 1, 1, C, 16'hbbbb, 1, 0, C, 0, 1, 0);
    idle("R10");
    // random traffic with a fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ad, sad;
      ad = {6'($urandom % 3), 2'($urandom % 4)};
      sad = ($urandom % 3 == 0) ? ad : {6'($urandom % 3), 2'($urandom % 4)};
      cycle("R10", 1'($urandom % 4 != 0), 1'($urandom), ad, 16'($urandom),
            1'($urandom % 3 != 0), 1'($urandom), sad, 16'($urandom),
            1'($urandom), 16'($urandom));
    end
    idle("R2");
    idle("R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule